// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out two values for a single-register load or store: the address sent to memory, and the updated base value that may go back to the register file. The offset is either a 12-bit unsigned immediate or a second register value passed through a small shifter. The shifter takes only an immediate shift amount. Control inputs set three things: whether the offset is added or subtracted, whether the address is formed before or after indexing, and how the write-back bit is read. The block also raises a flag when a privileged instruction asks for its memory access to be treated as a user-mode access.

It sits between operand fetch and the memory interface. The caller presents the operands and control bits on the same cycle. The address, the new base, the write-back enable and the force-user flag come out together. With the default parameter setting they come out one clock later. Fetching operands, memory handshaking and register-file writes are done elsewhere.

Top module: `ls_addr_gen`

## Requirements
- R1: While `rst_n` is low, every output is zero. With the registered stage in place, `rst_n` going low clears the outputs at once, without waiting for a clock edge.
- R2: Offset direction and immediate form. With `reg_off_i`=0, the offset is `imm_i` zero-extended to 32 bits. The new base is base plus offset when `up_i`=1 and base minus offset when `up_i`=0, both modulo 2^32.
- R3: Address source. When `pre_i`=1, `addr_o` equals the new base. When `pre_i`=0, `addr_o` equals the unmodified `base_i`.
- R4: When `pre_i`=1, `wb_en_o` equals `wbit_i`.
- R5: When `pre_i`=0, `wb_en_o` is 1 whatever the value of `wbit_i`.
- R6: `force_user_o` is 1 exactly when `pre_i`=0, `wbit_i`=1 and `priv_i`=1.
- R7: When `priv_i`=0 (user mode), `force_user_o` is 0 for every combination of the other controls.
- R8: Register offset. With `reg_off_i`=1, the offset is `rm_i` shifted as set by `shctl_i`. The amount is `shctl_i[7:3]` and the kind is `shctl_i[2:1]`: 00 is logical left, 01 is logical right, 10 is arithmetic right, 11 is rotate right. `shctl_i[0]` is ignored, because a register-specified amount is not supported.
- R9: An encoded amount of 0 means a shift by 32 for logical right and for arithmetic right. Logical right then gives zero. Arithmetic right gives 32 copies of `rm_i[31]`.
- R10: Rotate right with encoded amount 0 is a one-bit rotate through carry. The result is `{carry_i, rm_i[31:1]}`.
- R11: Logical left with amount 0 passes `rm_i` through unchanged. `carry_i` affects only the R10 case.
- R12: With `REG_OUT`=1 (the default), the outputs reflect the inputs sampled at the previous rising edge of `clk`. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate offset |
| rm_i | input | 32 | Offset register value |
| shctl_i | input | 8 | Shift control: amount [7:3], kind [2:1], bit 0 ignored |
| reg_off_i | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 indexes before the access, 0 indexes after it |
| wbit_i | input | 1 | Write-back request (pre-indexed) or force-user request (post-indexed) |
| priv_i | input | 1 | 1 when the current mode is privileged |
| carry_i | input | 1 | Carry bit used by the rotate-through-carry case |
| addr_o | output | 32 | Transfer address |
| newbase_o | output | 32 | Indexed base value |
| wb_en_o | output | 1 | Base write-back enable |
| force_user_o | output | 1 | Treat the access as unprivileged |

## Verification
A privileged post-indexed transfer with the write-back bit set makes the block raise the forced-user flag and enable base write-back in the same cycle, while `addr_o` still carries the unindexed base. The table provokes this with a subtracted immediate and checks all three outputs in that one sample. A neighbouring vector keeps the same operands and clears the privilege bit, and the bench checks that the flag drops while write-back stays on. A second overlap checked the same way is a rotate-through-carry offset subtracted in pre-indexed form.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    // Shift kinds held in the two-bit kind field of the shift control
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_kind_e;

    // Indexing controls, grouped so that one port carries them
    typedef struct packed {
        logic up;
        logic pre;
        logic wbit;
        logic priv;
    } idx_ctl_t;

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
    import lsag_pkg::*;
#(
    parameter int W = 32,
    localparam int AMT_W = $clog2(W),
    localparam int CTL_W = AMT_W + 3
) (
    input  logic [W-1:0]     val_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             carry_i,
    output logic [W-1:0]     res_o
);

    logic [AMT_W-1:0] amt;
    sh_kind_e         kind;
    logic [2*W-1:0]   rot_dbl;
    logic             unused_regsel;

    assign amt           = ctl_i[CTL_W-1:3];
    assign kind          = sh_kind_e'(ctl_i[2:1]);
    // Bit 0 would select a register amount; that form is not supported
    assign unused_regsel = ctl_i[0];
    assign rot_dbl       = {val_i, val_i} >> amt;

    always_comb begin
        res_o = val_i;
        unique case (kind)
            SH_LSL: res_o = val_i << amt;
            SH_LSR: begin
                if (amt == '0) res_o = '0;
                else           res_o = val_i >> amt;
            end
            SH_ASR: begin
                if (amt == '0) res_o = {W{val_i[W-1]}};
                else           res_o = W'($signed(val_i) >>> amt);
            end
            SH_ROR: begin
                if (amt == '0) res_o = {carry_i, val_i[W-1:1]};
                else           res_o = rot_dbl[W-1:0];
            end
            default: res_o = val_i;
        endcase
    end

endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel #(
    parameter int W     = 32,
    parameter int IMM_W = 12,
    localparam int PAD_W = W - IMM_W
) (
    input  logic [IMM_W-1:0] imm_i,
    input  logic [W-1:0]     shifted_i,
    input  logic             use_reg_i,
    output logic [W-1:0]     off_o
);

    logic [W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_i};
        end else begin : g_nopad
            assign imm_ext = imm_i[W-1:0];
        end
    endgenerate

    assign off_o = use_reg_i ? shifted_i : imm_ext;

endmodule

// File: rtl/lsag_index.sv
module lsag_index
    import lsag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    input  idx_ctl_t     ctl_i,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] nbase_o,
    output logic         wb_o,
    output logic         fuser_o
);

    logic [W-1:0] sum;

    always_comb begin
        if (ctl_i.up) sum = base_i + off_i;
        else          sum = base_i - off_i;

        nbase_o = sum;
        addr_o  = ctl_i.pre ? sum : base_i;

        // Post-indexed forms always update the base; their W bit
        // instead asks for an unprivileged access when privileged.
        wb_o    = ctl_i.pre ? ctl_i.wbit : 1'b1;
        fuser_o = !ctl_i.pre && ctl_i.wbit && ctl_i.priv;
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import lsag_pkg::*;
#(
    parameter int W       = 32,
    parameter int IMM_W   = 12,
    parameter bit REG_OUT = 1'b1,
    localparam int AMT_W  = $clog2(W),
    localparam int CTL_W  = AMT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [W-1:0]     rm_i,
    input  logic [CTL_W-1:0] shctl_i,
    input  logic             reg_off_i,
    input  logic             up_i,
    input  logic             pre_i,
    input  logic             wbit_i,
    input  logic             priv_i,
    input  logic             carry_i,
    output logic [W-1:0]     addr_o,
    output logic [W-1:0]     newbase_o,
    output logic             wb_en_o,
    output logic             force_user_o
);

    typedef struct packed {
        logic [W-1:0] addr;
        logic [W-1:0] nbase;
        logic         wb;
        logic         fuser;
    } res_t;

    logic [W-1:0] shifted;
    logic [W-1:0] offset;
    logic [W-1:0] idx_addr;
    logic [W-1:0] idx_nbase;
    logic         idx_wb;
    logic         idx_fuser;
    idx_ctl_t     ctl;
    res_t         res_d;
    res_t         res_q;

    assign ctl = '{up: up_i, pre: pre_i, wbit: wbit_i, priv: priv_i};

    lsag_shifter #(.W(W)) u_shift (
        .val_i   (rm_i),
        .ctl_i   (shctl_i),
        .carry_i (carry_i),
        .res_o   (shifted)
    );

    lsag_offset_sel #(.W(W), .IMM_W(IMM_W)) u_osel (
        .imm_i     (imm_i),
        .shifted_i (shifted),
        .use_reg_i (reg_off_i),
        .off_o     (offset)
    );

    lsag_index #(.W(W)) u_idx (
        .base_i  (base_i),
        .off_i   (offset),
        .ctl_i   (ctl),
        .addr_o  (idx_addr),
        .nbase_o (idx_nbase),
        .wb_o    (idx_wb),
        .fuser_o (idx_fuser)
    );

    always_comb begin
        res_d.addr  = idx_addr;
        res_d.nbase = idx_nbase;
        res_d.wb    = idx_wb;
        res_d.fuser = idx_fuser;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = rst_n ? res_d : '0;
        end
    endgenerate

    assign addr_o       = res_q.addr;
    assign newbase_o    = res_q.nbase;
    assign wb_en_o      = res_q.wb;
    assign force_user_o = res_q.fuser;

endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] base_i,
    input logic         pre_i,
    input logic         wbit_i,
    input logic         priv_i,
    input logic [W-1:0] addr_o,
    input logic [W-1:0] newbase_o,
    input logic         wb_en_o,
    input logic         force_user_o
);

    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R1: outputs are cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (addr_o == '0 && newbase_o == '0 &&
                                      !wb_en_o && !force_user_o);
        end
    end

    generate
        if (REG_OUT) begin : g_seq
            a_r3_post_addr: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                !$past(pre_i) |-> addr_o == $past(base_i));

            a_r3_pre_addr: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                $past(pre_i) |-> addr_o == newbase_o);

            a_r4_pre_wb: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                $past(pre_i) |-> wb_en_o == $past(wbit_i));

            a_r5_post_wb: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                !$past(pre_i) |-> wb_en_o);

            a_r6_force_cause: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                force_user_o |-> ($past(wbit_i) && !$past(pre_i) && $past(priv_i)));

            a_r7_user_noforce: assert property (@(posedge clk)
                disable iff (!rst_n || !primed_q)
                !$past(priv_i) |-> !force_user_o);
        end
    endgenerate

endmodule

bind ls_addr_gen lsag_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_i       (base_i),
    .pre_i        (pre_i),
    .wbit_i       (wbit_i),
    .priv_i       (priv_i),
    .addr_o       (addr_o),
    .newbase_o    (newbase_o),
    .wb_en_o      (wb_en_o),
    .force_user_o (force_user_o)
);

// File: tb/sim_ls_addr_gen.sv
`timescale 1ns/1ps
module sim_ls_addr_gen;

    typedef struct packed {
        logic [31:0] base;
        logic [11:0] imm;
        logic [31:0] rm;
        logic [7:0]  sh;
        logic        regsel;
        logic        up;
        logic        pre;
        logic        w;
        logic        priv;
        logic        cin;
        logic [31:0] e_addr;
        logic [31:0] e_nb;
        logic        e_wb;
        logic        e_fu;
    } vec_t;

    localparam int NV = 15;
    // fields: base imm rm sh reg up pre w priv cin | addr newbase wb fu
    localparam vec_t VT [NV] = '{
        // 0 R2 R3 R4: pre, add immediate, no write-back
        '{32'h1000_0000, 12'h010, 32'h0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
          32'h1000_0010, 32'h1000_0010, 1'b0, 1'b0},
        // 1 R2 R4: pre, subtract immediate, write-back
        '{32'h0000_0100, 12'h0FF, 32'h0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
          32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
        // 2 R3 R5: post, W=0 still writes back
        '{32'h0000_2000, 12'h004, 32'h0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
          32'h0000_2000, 32'h0000_2004, 1'b1, 1'b0},
        // 3 R6 R5: post, W=1, privileged -> force user and write-back together
        '{32'h0000_3000, 12'h008, 32'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
          32'h0000_3000, 32'h0000_2FF8, 1'b1, 1'b1},
        // 4 R7: same in user mode, no forcing
        '{32'h0000_3000, 12'h008, 32'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
          32'h0000_3000, 32'h0000_2FF8, 1'b1, 1'b0},
        // 5 R8: LSL by 4
        '{32'h0, 12'h000, 32'h0000_00F1, 8'h20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
          32'h0000_0F10, 32'h0000_0F10, 1'b0, 1'b0},
        // 6 R8 R11: LSR by 8, bit0 set and carry set are ignored
        '{32'h0000_0100, 12'h000, 32'h1234_5678, 8'h43, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
          32'h0012_3556, 32'h0012_3556, 1'b0, 1'b0},
        // 7 R8: ASR by 4, subtracted
        '{32'h0, 12'h000, 32'h8000_0000, 8'h24, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
          32'h0800_0000, 32'h0800_0000, 1'b0, 1'b0},
        // 8 R8 R7: ROR by 8, post, user mode
        '{32'h0000_0010, 12'h000, 32'h0000_00AB, 8'h46, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
          32'h0000_0010, 32'hAB00_0010, 1'b1, 1'b0},
        // 9 R9: LSR amount 0 means 32 -> zero offset
        '{32'h0000_0055, 12'h000, 32'hFFFF_FFFF, 8'h02, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
          32'h0000_0055, 32'h0000_0055, 1'b1, 1'b0},
        // 10 R9: ASR amount 0 means 32 -> all sign bits
        '{32'h0000_0010, 12'h000, 32'h8000_0001, 8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
          32'h0000_000F, 32'h0000_000F, 1'b0, 1'b0},
        // 11 R10: rotate through carry, carry 1
        '{32'h0, 12'h000, 32'h0000_0003, 8'h06, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
          32'h8000_0001, 32'h8000_0001, 1'b0, 1'b0},
        // 12 R10: rotate through carry, carry 0, subtracted
        '{32'h0000_0020, 12'h000, 32'h0000_0003, 8'h06, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
          32'h0000_001F, 32'h0000_001F, 1'b0, 1'b0},
        // 13 R11: LSL amount 0 passes through, carry ignored
        '{32'h0, 12'h000, 32'h1234_5678, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
          32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0},
        // 14 R2: largest immediate wraps modulo 2^32
        '{32'hFFFF_F001, 12'hFFF, 32'h0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
          32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [11:0] imm_i = '0;
    logic [31:0] rm_i = '0;
    logic [7:0]  shctl_i = '0;
    logic        reg_off_i = 1'b0;
    logic        up_i = 1'b0;
    logic        pre_i = 1'b0;
    logic        wbit_i = 1'b0;
    logic        priv_i = 1'b0;
    logic        carry_i = 1'b0;
    logic [31:0] addr_o;
    logic [31:0] newbase_o;
    logic        wb_en_o;
    logic        force_user_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ls_addr_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_i       (base_i),
        .imm_i        (imm_i),
        .rm_i         (rm_i),
        .shctl_i      (shctl_i),
        .reg_off_i    (reg_off_i),
        .up_i         (up_i),
        .pre_i        (pre_i),
        .wbit_i       (wbit_i),
        .priv_i       (priv_i),
        .carry_i      (carry_i),
        .addr_o       (addr_o),
        .newbase_o    (newbase_o),
        .wb_en_o      (wb_en_o),
        .force_user_o (force_user_o)
    );

    task automatic drive(input vec_t v);
        base_i    = v.base;
        imm_i     = v.imm;
        rm_i      = v.rm;
        shctl_i   = v.sh;
        reg_off_i = v.regsel;
        up_i      = v.up;
        pre_i     = v.pre;
        wbit_i    = v.w;
        priv_i    = v.priv;
        carry_i   = v.cin;
    endtask

    task automatic check_out(input string req, input logic [31:0] ea,
                             input logic [31:0] enb, input logic ewb,
                             input logic efu);
        n_chk++;
        if (addr_o !== ea || newbase_o !== enb || wb_en_o !== ewb ||
            force_user_o !== efu) begin
            n_bad++;
            $display("FAIL %s: got addr=%h nb=%h wb=%b fu=%b, expected addr=%h nb=%h wb=%b fu=%b",
                     req, addr_o, newbase_o, wb_en_o, force_user_o, ea, enb, ewb, efu);
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero while held in reset, even with live inputs
        drive(VT[3]);
        repeat (3) @(negedge clk);
        check_out("R1 reset", 32'h0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table: inputs at one falling edge, result one edge later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            @(negedge clk);
            check_out($sformatf("vector %0d", i), VT[i].e_addr, VT[i].e_nb,
                      VT[i].e_wb, VT[i].e_fu);
        end

        // R12: outputs hold between edges, then follow at the next edge
        @(negedge clk);
        drive(VT[3]);
        #5;
        check_out("R12 hold before edge", 32'h0, 32'h0, 1'b1, 1'b0);
        @(negedge clk);
        check_out("R12 update after edge", 32'h0000_3000, 32'h0000_2FF8, 1'b1, 1'b1);

        // R1: asynchronous reset mid-run clears at once
        #2;
        rst_n = 1'b0;
        #1;
        check_out("R1 async clear", 32'h0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 R4: same post-indexed operands with W=0 then pre with W=0
        drive(VT[2]);
        wbit_i = 1'b0;
        priv_i = 1'b0;
        @(negedge clk);
        check_out("R5 post W=0 user", 32'h0000_2000, 32'h0000_2004, 1'b1, 1'b0);
        pre_i = 1'b1;
        @(negedge clk);
        check_out("R4 pre W=0", 32'h0000_2004, 32'h0000_2004, 1'b0, 1'b0);

        // R6: pre-indexed W=1 privileged does not force user
        wbit_i = 1'b1;
        priv_i = 1'b1;
        @(negedge clk);
        check_out("R6 pre W=1 no force", 32'h0000_2004, 32'h0000_2004, 1'b1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule